// File: doc/BRIEF.md
# External Trigger Clocked Event Counter

This block is the front end of a timer whose counter is advanced by an external event rather than by the timer clock. One of sixteen trigger sources is picked: a dedicated pin or one of fifteen on-chip signals. An optional inversion selects which edge is active. The chosen signal is brought into the timer clock domain by a two-flop synchroniser and then divided by a power-of-two prescaler. A programmable digital filter rejects short pulses. Each accepted active edge becomes one single-cycle count step.

The count step reaches the counter only when the external-event mode enable and the global count enable are both set. An edge that arrives while either enable is clear is lost. The counter is a free-running up-counter that wraps to zero. Software-style configuration is applied directly through static control inputs. Those inputs are expected to change only while the external-event mode is disabled.

The prescaler counts completed active phases of the synchronised signal. It lets the high phase of every ratio-th cycle through unchanged, so the filter still sees the real pulse width.

Top module: `trig_clk_counter`

## Requirements
- R1: `src_sel` = 0 selects `trig_pin`; `src_sel` = k (1..15) selects `trig_int[k-1]`. Activity on any source that is not selected leaves `count` unchanged.
- R2: `inv_pol` = 0 makes rising edges of the selected source active. `inv_pol` = 1 inverts the source, so its falling edges are counted.
- R3: `psc_sel` values 0, 1, 2 and 3 divide by 1, 2, 4 and 8. With a ratio D, the count steps on the D-th, 2D-th, … active edge after the prescaler was cleared. The prescaler clears while `ext_mode_en` = 0 and in any cycle in which `psc_sel` differs from its value one cycle earlier.
- R4: With `flt_sel` = 0 there is no filtering. With `flt_sel` = f ≠ 0, a new level of the prescaled signal is accepted only after it has been seen for 2·f consecutive timer clocks. A pulse shorter than that produces no count.
- R5: `count` advances only when `ext_mode_en` = 1 and `cnt_en` = 1. Edges that arrive while either is 0 produce no increment, neither then nor later.
- R6: Consider `psc_sel` = 0 and `flt_sel` = 0, with the source changed between clock edges. `count` shows the increment after the third rising clock edge following the change: two synchroniser stages plus the edge register. Each accepted edge advances `count` by exactly one.
- R7: A selected source whose high and low phases each last two timer clocks (a quarter of the clock rate) has every active edge counted.
- R8: `count` is CNT_W bits wide (32 by default), steps only by +1, and wraps from all ones to zero.
- R9: While `rst_n` is low, `count` is zero; assertion of `rst_n` clears it without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trig_pin | input | 1 | Dedicated external trigger input (source 0) |
| trig_int | input | N_SRC-1 (15) | On-chip trigger sources 1..15 |
| src_sel | input | 4 | Trigger source select |
| inv_pol | input | 1 | 1 inverts the trigger (falling edge active) |
| psc_sel | input | PSC_W (2) | Prescaler ratio select, divide by 2^psc_sel |
| flt_sel | input | FLT_W (4) | Filter setting, 0 = off, f = 2·f clock stability |
| ext_mode_en | input | 1 | External-event clock mode enable |
| cnt_en | input | 1 | Global counter enable |
| count | output | CNT_W (32) | Counter value |

## Verification
The hardest states to reach from the ports are those inside the prescaler and filter. These are the phase of the divider after a partial run of edges, and a pulse exactly one clock shorter than the filter window. The bench reaches the first state by sending an incomplete group of edges, then dropping the mode enable for one cycle to clear the phase. It then shows that the next full group is needed before a count appears. For the filter it drives pulses of precisely 2·f−1 and 2·f clocks and observes that only the longer one moves the counter. Counter wrap is reached with a narrowed counter fed at the quarter-rate limit, which also exercises the synchroniser at its ceiling.

// File: rtl/trig_clk_pkg.sv
package trig_clk_pkg;

  // Number of consecutive stable clocks a filter setting demands.
  function automatic int unsigned flt_len(input int unsigned setting);
    return 2 * setting;
  endfunction

  // Last phase index of the prescaler for a given ratio select.
  function automatic int unsigned div_last(input int unsigned setting);
    return (1 << setting) - 1;
  endfunction

endpackage

// File: rtl/tcp_src_cond.sv
module tcp_src_cond #(
  parameter int N_SRC       = 16,
  parameter int SEL_W       = $clog2(N_SRC),
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] srcs,
  input  logic [SEL_W-1:0] sel,
  input  logic             inv,
  output logic             sync_o
);

  logic                   raw;
  logic [SYNC_STAGES-1:0] stg_d;
  logic [SYNC_STAGES-1:0] stg_q;

  always_comb begin
    raw = srcs[sel] ^ inv;
  end

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign stg_d[i] = raw;
      end else begin : g_next
        assign stg_d[i] = stg_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q <= stg_d;
    end
  end

  assign sync_o = stg_q[SYNC_STAGES-1];

endmodule

// File: rtl/tcp_prescaler.sv
module tcp_prescaler
  import trig_clk_pkg::*;
#(
  parameter  int PSC_W = 2,
  localparam int PH_W  = (1 << PSC_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig,
  input  logic [PSC_W-1:0] psc_sel,
  input  logic             run,
  output logic             lvl
);

  logic             sig_q;
  logic [PSC_W-1:0] sel_q;
  logic [PH_W-1:0]  ph_q;
  logic [PH_W-1:0]  ph_d;
  logic [PH_W-1:0]  last;
  logic             fall;
  logic             clr;

  always_comb begin
    last = PH_W'(div_last(int'(psc_sel)));
    fall = sig_q & ~sig;
    clr  = !run || (psc_sel != sel_q);
    ph_d = ph_q;
    if (clr) begin
      ph_d = '0;
    end else if (fall) begin
      ph_d = (ph_q == last) ? '0 : ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_q <= 1'b0;
      sel_q <= '0;
      ph_q  <= '0;
    end else begin
      sig_q <= sig;
      sel_q <= psc_sel;
      ph_q  <= ph_d;
    end
  end

  // Only the active phase of the ratio-th cycle passes.
  assign lvl = sig & (ph_q == last);

  AST_PSC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) !run |=> ph_q == '0); // R3

endmodule

// File: rtl/tcp_filter.sv
module tcp_filter
  import trig_clk_pkg::*;
#(
  parameter  int FLT_W = 4,
  localparam int LEN_W = FLT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [FLT_W-1:0] flt_sel,
  output logic             dout
);

  logic             out_q;
  logic             out_d;
  logic [LEN_W-1:0] tmr_q;
  logic [LEN_W-1:0] tmr_d;
  logic [LEN_W-1:0] reload;
  logic             bypass;

  always_comb begin
    reload = LEN_W'(flt_len(int'(flt_sel))) - 1'b1;
    bypass = (flt_sel == '0);
    out_d  = out_q;
    tmr_d  = tmr_q;
    if (bypass) begin
      out_d = din;
      tmr_d = reload;
    end else if (din == out_q) begin
      tmr_d = reload;
    end else if (tmr_q == '0) begin
      out_d = din;
      tmr_d = reload;
    end else begin
      tmr_d = tmr_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
      tmr_q <= '1;
    end else begin
      out_q <= out_d;
      tmr_q <= tmr_d;
    end
  end

  assign dout = bypass ? din : out_q;

  AST_FLT_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (flt_sel != '0 && din == out_q) |=> $stable(out_q)); // R4

endmodule

// File: rtl/tcp_edge_count.sv
module tcp_edge_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl,
  input  logic             ext_en,
  input  logic             cnt_en,
  output logic [CNT_W-1:0] count
);

  logic             prev_q;
  logic             pulse;
  logic             step;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    pulse = lvl & ~prev_q;
    step  = pulse & ext_en & cnt_en;
    cnt_d = step ? cnt_q + 1'b1 : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= lvl;
      cnt_q  <= cnt_d;
    end
  end

  assign count = cnt_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) pulse |=> !pulse); // R6
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) !$stable(cnt_q) |-> cnt_q == $past(cnt_q) + CNT_W'(1)); // R8
  AST_CNT_GATED: assert property (@(posedge clk) disable iff (!rst_n) !(ext_en && cnt_en) |=> $stable(cnt_q)); // R5

endmodule

// File: rtl/trig_clk_counter.sv
module trig_clk_counter #(
  parameter  int N_SRC       = 16,
  parameter  int PSC_W       = 2,
  parameter  int FLT_W       = 4,
  parameter  int CNT_W       = 32,
  parameter  int SYNC_STAGES = 2,
  localparam int SEL_W       = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_pin,
  input  logic [N_SRC-2:0] trig_int,
  input  logic [SEL_W-1:0] src_sel,
  input  logic             inv_pol,
  input  logic [PSC_W-1:0] psc_sel,
  input  logic [FLT_W-1:0] flt_sel,
  input  logic             ext_mode_en,
  input  logic             cnt_en,
  output logic [CNT_W-1:0] count
);

  logic [1:0]       rst_pipe_q;
  logic             rst_int_n;
  logic [N_SRC-1:0] srcs;
  logic             trig_sync;
  logic             trig_div;
  logic             trig_flt;

  // Reset: asserted asynchronously, released after two clocks.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_pipe_q[1];
  assign srcs      = {trig_int, trig_pin};

  tcp_src_cond #(
    .N_SRC       (N_SRC),
    .SEL_W       (SEL_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_src (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .srcs   (srcs),
    .sel    (src_sel),
    .inv    (inv_pol),
    .sync_o (trig_sync)
  );

  tcp_prescaler #(
    .PSC_W (PSC_W)
  ) u_psc (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .sig     (trig_sync),
    .psc_sel (psc_sel),
    .run     (ext_mode_en),
    .lvl     (trig_div)
  );

  tcp_filter #(
    .FLT_W (FLT_W)
  ) u_flt (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .din     (trig_div),
    .flt_sel (flt_sel),
    .dout    (trig_flt)
  );

  tcp_edge_count #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .lvl    (trig_flt),
    .ext_en (ext_mode_en),
    .cnt_en (cnt_en),
    .count  (count)
  );

  AST_RST_CLEAR: assert property (@(posedge clk) !rst_n |-> count == '0); // R9

endmodule

// File: tb/trig_clk_counter_test.sv
module trig_clk_counter_test;

  localparam int CLK_PERIOD = 10;
  localparam int CW         = 8;

  typedef struct packed {
    logic [3:0] src;
    logic       inv;
    logic [1:0] psc;
    logic [3:0] flt;
    logic [7:0] n;
    logic [7:0] exp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{4'd0,  1'b0, 2'd0, 4'd0,  8'd3,  8'd3},
    '{4'd5,  1'b0, 2'd1, 4'd0,  8'd6,  8'd3},
    '{4'd15, 1'b1, 2'd0, 4'd0,  8'd4,  8'd4},
    '{4'd1,  1'b0, 2'd2, 4'd0,  8'd8,  8'd2},
    '{4'd9,  1'b1, 2'd3, 4'd0,  8'd16, 8'd2},
    '{4'd3,  1'b0, 2'd0, 4'd4,  8'd5,  8'd5},
    '{4'd7,  1'b0, 2'd1, 4'd15, 8'd4,  8'd2},
    '{4'd12, 1'b1, 2'd2, 4'd2,  8'd12, 8'd3}
  };

  logic          clk;
  logic          rst_n;
  logic          trig_pin;
  logic [14:0]   trig_int;
  logic [3:0]    src_sel;
  logic          inv_pol;
  logic [1:0]    psc_sel;
  logic [3:0]    flt_sel;
  logic          ext_mode_en;
  logic          cnt_en;
  logic [CW-1:0] count;

  int errors;
  int checks;
  bit done;

  trig_clk_counter #(.CNT_W(CW)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig_pin    (trig_pin),
    .trig_int    (trig_int),
    .src_sel     (src_sel),
    .inv_pol     (inv_pol),
    .psc_sel     (psc_sel),
    .flt_sel     (flt_sel),
    .ext_mode_en (ext_mode_en),
    .cnt_en      (cnt_en),
    .count       (count)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_src(input int idx, input logic v);
    if (idx == 0) trig_pin = v;
    else trig_int[idx-1] = v;
  endtask

  // Drive the active level (relative to inv_pol) on one source, then idle.
  task automatic pulse(input int idx, input int hi, input int lo);
    set_src(idx, ~inv_pol);
    tick(hi);
    set_src(idx, inv_pol);
    tick(lo);
  endtask

  task automatic configure(input int src, input logic inv, input int psc, input int flt);
    ext_mode_en = 1'b0;
    trig_pin    = inv;
    trig_int    = {15{inv}};
    inv_pol     = inv;
    src_sel     = 4'(src);
    psc_sel     = 2'(psc);
    flt_sel     = 4'(flt);
    tick(40);
    ext_mode_en = 1'b1;
    cnt_en      = 1'b1;
    tick(4);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [CW-1:0] c0;
    errors = 0;
    checks = 0;
    done   = 1'b0;
    rst_n = 1'b0;
    trig_pin = 1'b0;
    trig_int = '0;
    src_sel = '0;
    inv_pol = 1'b0;
    psc_sel = '0;
    flt_sel = '0;
    ext_mode_en = 1'b0;
    cnt_en = 1'b0;
    tick(3);
    check("R9 reset value", count, 8'd0);
    rst_n = 1'b1;
    tick(5);

    // Table of configurations and expected count deltas (R1, R2, R3, R4).
    for (int v = 0; v < 8; v++) begin
      configure(int'(VECS[v].src), VECS[v].inv, int'(VECS[v].psc), int'(VECS[v].flt));
      c0 = count;
      for (int e = 0; e < int'(VECS[v].n); e++) pulse(int'(VECS[v].src), 34, 34);
      tick(10);
      check($sformatf("R3 R2 R1 R4 vector %0d", v), count, c0 + VECS[v].exp);
    end

    // R6: exact latency through synchroniser and edge register.
    configure(0, 1'b0, 0, 0);
    c0 = count;
    trig_pin = 1'b1;
    tick(2);
    check("R6 no count before third edge", count, c0);
    tick(1);
    check("R6 count after third edge", count, c0 + 8'd1);
    trig_pin = 1'b0;
    tick(10);

    // R1: unselected sources have no effect.
    configure(4, 1'b0, 0, 0);
    c0 = count;
    pulse(0, 5, 5);
    pulse(1, 5, 5);
    pulse(3, 5, 5);
    pulse(5, 5, 5);
    pulse(15, 5, 5);
    check("R1 unselected sources ignored", count, c0);
    pulse(4, 5, 10);
    check("R1 selected source counted", count, c0 + 8'd1);

    // R5: either enable low blocks counting.
    configure(0, 1'b0, 0, 0);
    c0 = count;
    ext_mode_en = 1'b0;
    for (int e = 0; e < 3; e++) pulse(0, 5, 5);
    ext_mode_en = 1'b1;
    tick(10);
    check("R5 mode disabled", count, c0);
    cnt_en = 1'b0;
    for (int e = 0; e < 3; e++) pulse(0, 5, 5);
    cnt_en = 1'b1;
    tick(10);
    check("R5 counter disabled", count, c0);

    // R3: disabling mode clears a partial prescaler phase.
    configure(2, 1'b0, 2, 0);
    c0 = count;
    for (int e = 0; e < 3; e++) pulse(2, 5, 5);
    ext_mode_en = 1'b0;
    tick(1);
    ext_mode_en = 1'b1;
    tick(2);
    for (int e = 0; e < 3; e++) pulse(2, 5, 5);
    check("R3 cleared phase needs full group", count, c0);
    pulse(2, 5, 10);
    check("R3 fourth edge after clear counts", count, c0 + 8'd1);

    // R4: filter window boundary, f=3 needs 6 clocks.
    configure(6, 1'b0, 0, 3);
    c0 = count;
    pulse(6, 5, 40);
    check("R4 pulse one clock short ignored", count, c0);
    pulse(6, 6, 40);
    check("R4 pulse of full window counted", count, c0 + 8'd1);

    // R9: asynchronous clear in the middle of a run.
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R9 asynchronous clear", count, 8'd0);
    tick(2);
    rst_n = 1'b1;
    tick(5);

    // R7 and R8: quarter-rate input, counter wraps.
    configure(0, 1'b0, 0, 0);
    for (int e = 0; e < 261; e++) pulse(0, 2, 2);
    tick(6);
    check("R7 R8 quarter rate with wrap", count, 8'd5);

    finish_run();
  end

endmodule